// File: doc/BRIEF.md
# Raster Scanline Timing and Fetch Sequencer

This block keeps the beam position for a raster frame of `LINES` scanlines (262 by default), each `DOTS` dots long (341 by default). It raises the vertical-blank flag and its interrupt at the start of the blanking period. At the start of the pre-render line, the last line of the frame, it drops the flag and pulses a clear for the externally held sprite status flags. On every second frame it shortens the pre-render line by one dot, but only while rendering is enabled.

On the visible lines and the pre-render line, the background fetch pipeline runs on an eight-dot cadence. In each eight-dot group the sequencer issues one strobe each for:
- the shifter reload,
- the tile-name byte,
- the attribute byte,
- the two pattern planes.

It also forms the pattern address that the pattern strobes use. It tells the scroll address register when to step its column and its row. Every output is a registered level or a registered strobe, aligned with the dot and line counts presented in the same cycle.

Top module: `raster_seq`

## Requirements
- R1: After synchronous reset `rst`, the counts are line 0, dot 0 with even parity. The dot count climbs by one per clock up to `DOTS-1` and then returns to 0. When the dot count wraps, the line count advances, and the line count wraps from `LINES-1` to 0.
- R2: `vblank` is high in the cycle whose counts read line `VBL_LINE` (241), dot 1. It stays high until it is cleared.
- R3: In the cycle showing line `LINES-1` (261), dot 1, `vblank` is low and `flagClear` is high. `flagClear` is high in no other cycle.
- R4: When `statusRd` is sampled high at a clock edge, `vblank` is low after that edge, unless that same edge enters the set point of R2, in which case setting wins.
- R5: `nmi` is high after an edge exactly when `vblank` is high after that edge and `nmiEn` was high at that edge.
- R6: A parity bit toggles each time the frame wraps. When the parity is odd, the line is `LINES-1` and the dot is `DOTS-3`, and `renderEn` is high at the edge, the next dot is `DOTS-1`. Dot `DOTS-2` is therefore skipped. With `renderEn` low, no dot is skipped.
- R7: On lines below `VIS_LINES` (240) and on line `LINES-1`, for dots 1 to `FETCH_DOTS` (256), the phase (dot-1) mod 8 selects the strobe: 0 `shiftReload`, 1 `ntFetch`, 3 `atFetch`, 5 `patLoFetch`, 7 `patHiFetch`. None of these strobes appears anywhere else.
- R8: On the same rendered lines, `incCol` and `incRow` are both high at dot `FETCH_DOTS` (256), and `incCol` alone is high at dot `COL2_DOT` (328). Neither appears at any other time.
- R9: During `patLoFetch` and `patHiFetch`, `patAddr` equals `tableSel`*0x1000 + `tileIdx`*16 + `fineY`, plus 8 during `patHiFetch`. That is, bit layout {tableSel, tileIdx[7:0], plane, fineY[2:0]}. The inputs are those sampled at the preceding edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| renderEn | input | 1 | Background or sprite display enabled |
| nmiEn | input | 1 | Interrupt output enable |
| statusRd | input | 1 | Status register read pulse |
| tableSel | input | 1 | Background pattern table select |
| tileIdx | input | 8 | Tile index from the fetched name byte |
| fineY | input | 3 | Fine vertical scroll |
| dotCnt | output | clog2(DOTS) | Current dot |
| lineCnt | output | clog2(LINES) | Current scanline |
| shiftReload | output | 1 | Reload background shifters |
| ntFetch | output | 1 | Fetch tile-name byte |
| atFetch | output | 1 | Fetch attribute byte |
| patLoFetch | output | 1 | Fetch low pattern plane |
| patHiFetch | output | 1 | Fetch high pattern plane |
| patAddr | output | 13 | Pattern fetch address |
| incCol | output | 1 | Step scroll column |
| incRow | output | 1 | Step scroll row |
| vblank | output | 1 | Vertical-blank status |
| nmi | output | 1 | Vertical-blank interrupt request |
| flagClear | output | 1 | Clear sprite-zero-hit and overflow flags |

## Verification
The in-design properties check the following on every cycle:
- the dot count stays in range and wraps;
- the odd-frame skip lands on the last dot;
- the fetch strobes are mutually exclusive;
- the set and clear events move `vblank`;
- `nmi` never stands without `vblank`.

The scenarios are needed for the rest:
- the exact phase placement of each fetch;
- the increment dots;
- the pattern address contents;
- setting winning over a status read;
- gating by `nmiEn`;
- the absence of a skip when rendering is off.

These are compared against an independent reference model in the bench, run at reduced frame dimensions so that many frames and both parities pass quickly.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int TILE_W = 8;
  localparam int FY_W   = 3;
  localparam int PAT_W  = 1 + TILE_W + 1 + FY_W;

  typedef struct packed {
    logic reload;
    logic ntF;
    logic atF;
    logic patLo;
    logic patHi;
    logic incX;
    logic incY;
    logic setVbl;
    logic clrVbl;
  } seqStrb_t;
endpackage

// File: rtl/raster_ctrl.sv
module raster_ctrl
  import raster_pkg::*;
#(
  parameter int DOTS       = 341,
  parameter int LINES      = 262,
  parameter int VIS_LINES  = 240,
  parameter int VBL_LINE   = 241,
  parameter int FETCH_DOTS = 256,
  parameter int COL2_DOT   = 328
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       renderEn,
  output logic [$clog2(DOTS)-1:0]    dotQ,
  output logic [$clog2(LINES)-1:0]   lineQ,
  output seqStrb_t                   strb
);
  localparam int DW = $clog2(DOTS);
  localparam int LW = $clog2(LINES);
  localparam logic [DW-1:0] LAST_DOT  = DW'(DOTS - 1);
  localparam logic [DW-1:0] SKIP_FROM = DW'(DOTS - 3);
  localparam logic [DW-1:0] ONE_DOT   = DW'(1);
  localparam logic [DW-1:0] FETCH_END = DW'(FETCH_DOTS);
  localparam logic [DW-1:0] COL2      = DW'(COL2_DOT);
  localparam logic [LW-1:0] PRE_LINE  = LW'(LINES - 1);
  localparam logic [LW-1:0] VIS_END   = LW'(VIS_LINES);
  localparam logic [LW-1:0] VBL       = LW'(VBL_LINE);

  logic          oddQ, oddN;
  logic [DW-1:0] dotN, dotM1;
  logic [LW-1:0] lineN;
  logic          rendLine, inFetch;
  logic [2:0]    phase;

  always_comb begin
    dotN  = dotQ + ONE_DOT;
    lineN = lineQ;
    oddN  = oddQ;
    if (dotQ == LAST_DOT) begin
      dotN = '0;
      if (lineQ == PRE_LINE) begin
        lineN = '0;
        oddN  = ~oddQ;
      end else begin
        lineN = lineQ + LW'(1);
      end
    end else if (lineQ == PRE_LINE && dotQ == SKIP_FROM && oddQ && renderEn) begin
      dotN = LAST_DOT;
    end
  end

  always_comb begin
    rendLine = (lineN < VIS_END) || (lineN == PRE_LINE);
    inFetch  = rendLine && (dotN >= ONE_DOT) && (dotN <= FETCH_END);
    dotM1    = dotN - ONE_DOT;
    phase    = dotM1[2:0];
    strb.reload = inFetch && (phase == 3'd0);
    strb.ntF    = inFetch && (phase == 3'd1);
    strb.atF    = inFetch && (phase == 3'd3);
    strb.patLo  = inFetch && (phase == 3'd5);
    strb.patHi  = inFetch && (phase == 3'd7);
    strb.incX   = rendLine && ((dotN == FETCH_END) || (dotN == COL2));
    strb.incY   = rendLine && (dotN == FETCH_END);
    strb.setVbl = (lineN == VBL) && (dotN == ONE_DOT);
    strb.clrVbl = (lineN == PRE_LINE) && (dotN == ONE_DOT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dotQ  <= '0;
      lineQ <= '0;
      oddQ  <= 1'b0;
    end else begin
      dotQ  <= dotN;
      lineQ <= lineN;
      oddQ  <= oddN;
    end
  end

  // R1
  dot_range_chk: assert property (@(posedge clk) disable iff (rst) dotQ <= LAST_DOT);
  // R1
  dot_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (dotQ == LAST_DOT) |=> (dotQ == '0));
  // R6
  dot_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (lineQ == PRE_LINE && dotQ == SKIP_FROM && oddQ && renderEn) |=> (dotQ == LAST_DOT));
endmodule

// File: rtl/raster_dp.sv
module raster_dp
  import raster_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  seqStrb_t           strb,
  input  logic               nmiEn,
  input  logic               statusRd,
  input  logic               tableSel,
  input  logic [TILE_W-1:0]  tileIdx,
  input  logic [FY_W-1:0]    fineY,
  output logic               shiftReload,
  output logic               ntFetch,
  output logic               atFetch,
  output logic               patLoFetch,
  output logic               patHiFetch,
  output logic [PAT_W-1:0]   patAddr,
  output logic               incCol,
  output logic               incRow,
  output logic               vblank,
  output logic               nmi,
  output logic               flagClear
);
  logic vblN;

  always_comb begin
    if (strb.setVbl)                     vblN = 1'b1;
    else if (strb.clrVbl || statusRd)    vblN = 1'b0;
    else                                 vblN = vblank;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReload <= 1'b0;
      ntFetch     <= 1'b0;
      atFetch     <= 1'b0;
      patLoFetch  <= 1'b0;
      patHiFetch  <= 1'b0;
      patAddr     <= '0;
      incCol      <= 1'b0;
      incRow      <= 1'b0;
      vblank      <= 1'b0;
      nmi         <= 1'b0;
      flagClear   <= 1'b0;
    end else begin
      shiftReload <= strb.reload;
      ntFetch     <= strb.ntF;
      atFetch     <= strb.atF;
      patLoFetch  <= strb.patLo;
      patHiFetch  <= strb.patHi;
      patAddr     <= {tableSel, tileIdx, strb.patHi, fineY};
      incCol      <= strb.incX;
      incRow      <= strb.incY;
      vblank      <= vblN;
      nmi         <= vblN && nmiEn;
      flagClear   <= strb.clrVbl;
    end
  end

  // R7
  fetch_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({shiftReload, ntFetch, atFetch, patLoFetch, patHiFetch}));
  // R2
  vbl_set_chk: assert property (@(posedge clk) disable iff (rst) strb.setVbl |=> vblank);
  // R3
  vbl_clr_chk: assert property (@(posedge clk) disable iff (rst) strb.clrVbl |=> !vblank);
  // R5
  nmi_gate_chk: assert property (@(posedge clk) disable iff (rst) nmi |-> vblank);
endmodule

// File: rtl/raster_seq.sv
module raster_seq
  import raster_pkg::*;
#(
  parameter int DOTS       = 341,
  parameter int LINES      = 262,
  parameter int VIS_LINES  = 240,
  parameter int VBL_LINE   = 241,
  parameter int FETCH_DOTS = 256,
  parameter int COL2_DOT   = 328
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      renderEn,
  input  logic                      nmiEn,
  input  logic                      statusRd,
  input  logic                      tableSel,
  input  logic [7:0]                tileIdx,
  input  logic [2:0]                fineY,
  output logic [$clog2(DOTS)-1:0]   dotCnt,
  output logic [$clog2(LINES)-1:0]  lineCnt,
  output logic                      shiftReload,
  output logic                      ntFetch,
  output logic                      atFetch,
  output logic                      patLoFetch,
  output logic                      patHiFetch,
  output logic [12:0]               patAddr,
  output logic                      incCol,
  output logic                      incRow,
  output logic                      vblank,
  output logic                      nmi,
  output logic                      flagClear
);
  seqStrb_t strb;

  raster_ctrl #(
    .DOTS(DOTS), .LINES(LINES), .VIS_LINES(VIS_LINES),
    .VBL_LINE(VBL_LINE), .FETCH_DOTS(FETCH_DOTS), .COL2_DOT(COL2_DOT)
  ) u_ctrl (
    .clk(clk), .rst(rst), .renderEn(renderEn),
    .dotQ(dotCnt), .lineQ(lineCnt), .strb(strb)
  );

  raster_dp u_dp (
    .clk(clk), .rst(rst), .strb(strb), .nmiEn(nmiEn), .statusRd(statusRd),
    .tableSel(tableSel), .tileIdx(tileIdx), .fineY(fineY),
    .shiftReload(shiftReload), .ntFetch(ntFetch), .atFetch(atFetch),
    .patLoFetch(patLoFetch), .patHiFetch(patHiFetch), .patAddr(patAddr),
    .incCol(incCol), .incRow(incRow), .vblank(vblank), .nmi(nmi),
    .flagClear(flagClear)
  );
endmodule

// File: tb/raster_seq_tb.sv
`timescale 1ns/1ps
module raster_seq_tb;
  localparam int DOTS = 40, LINES = 12, VIS = 6, VBL = 7, FETCH = 24, COL2 = 32;
  localparam int PRE = LINES - 1;
  localparam int DW = $clog2(DOTS), LW = $clog2(LINES);

  logic clk = 0, rst = 1, renderEn = 0, nmiEn = 0, statusRd = 0, tableSel = 0;
  logic [7:0] tileIdx = 0;
  logic [2:0] fineY = 0;
  logic [DW-1:0] dotCnt;
  logic [LW-1:0] lineCnt;
  logic shiftReload, ntFetch, atFetch, patLoFetch, patHiFetch, incCol, incRow;
  logic vblank, nmi, flagClear;
  logic [12:0] patAddr;

  always #10 clk = ~clk;

  raster_seq #(.DOTS(DOTS), .LINES(LINES), .VIS_LINES(VIS), .VBL_LINE(VBL),
               .FETCH_DOTS(FETCH), .COL2_DOT(COL2)) u_dut (.*);

  typedef struct packed {
    logic [15:0] dot, line;
    logic rl, nt, at, lo, hi, ix, iy, vb, nm, clr;
    logic [12:0] pa;
  } exp_t;

  exp_t q[$];
  int checks = 0, failures = 0, skipCnt = 0;
  int mDot = 0, mLine = 0;
  bit mOdd = 0, mVbl = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model: pushes the expected outputs after each edge
  always @(posedge clk) begin
    exp_t e;
    e = '0;
    if (rst) begin
      mDot = 0; mLine = 0; mOdd = 0; mVbl = 0;
    end else begin
      if (mDot == DOTS - 1) begin
        mDot = 0;
        if (mLine == PRE) begin mLine = 0; mOdd = ~mOdd; end
        else mLine++;
      end else if (mLine == PRE && mDot == DOTS - 3 && mOdd && renderEn) mDot = DOTS - 1;
      else mDot++;
      begin
        bit rend;
        int ph;
        rend = (mLine < VIS) || (mLine == PRE);
        ph = (mDot + 7) % 8;
        if (rend && mDot >= 1 && mDot <= FETCH) begin
          e.rl = (ph == 0); e.nt = (ph == 1); e.at = (ph == 3);
          e.lo = (ph == 5); e.hi = (ph == 7);
        end
        e.ix = rend && (mDot == FETCH || mDot == COL2);
        e.iy = rend && (mDot == FETCH);
      end
      e.clr = (mLine == PRE && mDot == 1);
      if (mLine == VBL && mDot == 1) mVbl = 1;
      else if (e.clr || statusRd) mVbl = 0;
      e.nm = mVbl && nmiEn;
      e.pa = {tableSel, tileIdx, e.hi, fineY};
    end
    e.dot = 16'(mDot); e.line = 16'(mLine); e.vb = mVbl;
    q.push_back(e);
  end

  // monitor: pops and compares away from the edge
  int prevDot = 0;
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(dotCnt == e.dot[DW-1:0], "R1 dot", dotCnt, e.dot);
      chk(lineCnt == e.line[LW-1:0], "R1 line", lineCnt, e.line);
      chk(vblank == e.vb, "R2/R4 vblank", vblank, e.vb);
      chk(flagClear == e.clr, "R3 flagClear", flagClear, e.clr);
      chk(nmi == e.nm, "R5 nmi", nmi, e.nm);
      chk({shiftReload, ntFetch, atFetch, patLoFetch, patHiFetch} ==
          {e.rl, e.nt, e.at, e.lo, e.hi}, "R7 fetch strobes",
          {shiftReload, ntFetch, atFetch, patLoFetch, patHiFetch},
          {e.rl, e.nt, e.at, e.lo, e.hi});
      chk({incCol, incRow} == {e.ix, e.iy}, "R8 increments",
          {incCol, incRow}, {e.ix, e.iy});
      if (e.lo || e.hi) chk(patAddr == e.pa, "R9 patAddr", patAddr, e.pa);
      if (!rst && prevDot == DOTS - 3 && dotCnt == DOTS - 1) skipCnt++;
      prevDot = dotCnt;
    end
  end

  task automatic run(input int n, input int rdPeriod);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tileIdx  = tileIdx + 8'd37;
      fineY    = fineY + 3'd1;
      if (i % 53 == 0) tableSel = ~tableSel;
      statusRd = (rdPeriod != 0) && (i % rdPeriod == 0);
    end
    @(negedge clk);
    statusRd = 0;
  endtask

  localparam int FRAME = DOTS * LINES;

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(dotCnt == 0 && lineCnt == 0, "R1 reset counts", {lineCnt, dotCnt}, 0);
    chk(!vblank && !nmi && !flagClear, "R2 reset vblank", {vblank, nmi, flagClear}, 0);
    rst = 0;
    renderEn = 1; nmiEn = 1;
    run(4 * FRAME, 0);                    // R6 skip on odd frames, R2/R3/R5/R7/R8/R9
    // R6 one skip per odd frame with rendering on
    chk(skipCnt == 2, "R6 skip count render on", skipCnt, 2);
    s0 = skipCnt;
    renderEn = 0;
    run(4 * FRAME, 0);
    // R6 no skip with rendering off
    chk(skipCnt == s0, "R6 no skip render off", skipCnt, s0);
    renderEn = 1;
    run(2 * FRAME, 29);                   // R4 status reads, incl. during vblank
    nmiEn = 0;
    run(FRAME, 0);                        // R5 gated off
    nmiEn = 1;
    run(FRAME / 2, 11);
    rst = 1;
    run(5, 0);
    rst = 0;
    run(2 * FRAME, 0);                    // R1 restart from reset mid-frame
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule